// File: doc/BRIEF.md
# Outlier-Rejecting Sample Averaging Filter

This block reduces a stream of sensor samples to one filtered value per group of samples. A small mode code selects how the result is formed. The block can pass each sample straight through. It can average a pair of samples. It can also gather a larger group, throw away one copy of the largest and one copy of the smallest value, and average what is left. The number of values left is always a power of two, so the division is a truncating right shift.

Samples arrive on a data bus qualified by a valid strobe. The mode is read on every valid sample. A group that is still open when the mode input changes is abandoned. The sample that arrives in the cycle of the change opens a new group under the new mode. Each result appears one clock after the sample that completes its group, and it is marked by a one-cycle valid pulse.

Top module: `olr_avg_filter`

## Requirements
- R1: After reset the valid output is low, the result output is zero and no group is open.
- R2: In mode 0, every valid sample is presented unchanged on the result one clock later, with the valid output high.
- R3: In mode 1, two valid samples form a group. The result is their sum shifted right by one, and the fraction is dropped.
- R4: In mode 2, four samples form a group. One maximum and one minimum are removed, and the sum of the other two is shifted right by one.
- R5: In mode 3, six samples form a group. One maximum and one minimum are removed, and the sum of the other four is shifted right by two.
- R6: In mode 4, ten samples form a group. One maximum and one minimum are removed, and the sum of the other eight is shifted right by three.
- R7: In mode 5, eighteen samples form a group. One maximum and one minimum are removed, and the sum of the other sixteen is shifted right by four. Eighteen samples of 4095 produce 4095.
- R8: When the largest or smallest value occurs more than once in a group, only one copy of each is removed.
- R9: Mode codes 6 and 7 behave exactly as mode 0.
- R10: If the mode input differs from the mode of an open group, that group is dropped and produces no result. A valid sample in that same cycle becomes the first sample of a new group under the new mode.
- R11: Cycles with the valid strobe low add nothing to a group and produce no result, provided the mode input is unchanged.
- R12: The valid output is a single-cycle pulse. It follows, by exactly one clock, the valid sample that completes a group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_i | input | 12 | Sample value |
| samp_vld_i | input | 1 | Sample qualifier |
| mode_i | input | 3 | Filter mode code (0..5, with 6 and 7 treated as 0) |
| res_o | output | 12 | Filtered result |
| res_vld_o | output | 1 | One-cycle pulse marking a new result |

## Verification
Two events can fall in the same clock cycle: a partial group is discarded because the mode changed, and the first sample of the following group is accepted. The bench provokes this by changing the mode while presenting a valid sample in the middle of a six-sample group. It then requires that the old group yields no pulse and that the pair average is built only from the new samples. A second case drops a group on an idle cycle and then confirms that a fresh four-sample group is averaged without any leftover samples from the dropped group.

// File: rtl/olr_pkg.sv
package olr_pkg;
    localparam int MAX_GROUP = 18;
    localparam int CNT_W     = $clog2(MAX_GROUP + 1);
    localparam int SHIFT_W   = 3;

    typedef struct packed {
        logic [CNT_W-1:0]   len;
        logic [SHIFT_W-1:0] shift;
        logic               reject;
    } grp_cfg_t;
endpackage

// File: rtl/olr_mode_decode.sv
module olr_mode_decode
    import olr_pkg::*;
#(
    parameter int MODE_W = 3
) (
    input  logic [MODE_W-1:0] mode_i,
    output grp_cfg_t          cfg_o
);
    always_comb begin
        cfg_o = '{len: CNT_W'(1), shift: '0, reject: 1'b0};
        case (mode_i)
            MODE_W'(1): cfg_o = '{len: CNT_W'(2),  shift: SHIFT_W'(1), reject: 1'b0};
            MODE_W'(2): cfg_o = '{len: CNT_W'(4),  shift: SHIFT_W'(1), reject: 1'b1};
            MODE_W'(3): cfg_o = '{len: CNT_W'(6),  shift: SHIFT_W'(2), reject: 1'b1};
            MODE_W'(4): cfg_o = '{len: CNT_W'(10), shift: SHIFT_W'(3), reject: 1'b1};
            MODE_W'(5): cfg_o = '{len: CNT_W'(18), shift: SHIFT_W'(4), reject: 1'b1};
            default:    cfg_o = '{len: CNT_W'(1),  shift: '0, reject: 1'b0};
        endcase
    end
endmodule

// File: rtl/olr_extreme_track.sv
module olr_extreme_track #(
    parameter int W = 12
) (
    input  logic         start_i,
    input  logic [W-1:0] samp_i,
    input  logic [W-1:0] hi_q_i,
    input  logic [W-1:0] lo_q_i,
    output logic [W-1:0] hi_d_o,
    output logic [W-1:0] lo_d_o
);
    localparam int LANES = 2;

    logic [W-1:0] held [LANES];
    logic [W-1:0] pick [LANES];

    assign held[0] = hi_q_i;
    assign held[1] = lo_q_i;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic beats;
        if (g == 0) begin : g_max
            assign beats = samp_i > held[g];
        end else begin : g_min
            assign beats = samp_i < held[g];
        end
        assign pick[g] = (start_i || beats) ? samp_i : held[g];
    end

    assign hi_d_o = pick[0];
    assign lo_d_o = pick[1];
endmodule

// File: rtl/olr_avg_filter.sv
module olr_avg_filter
    import olr_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int MODE_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] samp_i,
    input  logic                samp_vld_i,
    input  logic [MODE_W-1:0]   mode_i,
    output logic [SAMPLE_W-1:0] res_o,
    output logic                res_vld_o
);
    localparam int SUM_W = SAMPLE_W + $clog2(MAX_GROUP);

    typedef struct packed {
        logic [CNT_W-1:0]    cnt;
        logic [MODE_W-1:0]   mode;
        logic [SUM_W-1:0]    sum;
        logic [SAMPLE_W-1:0] hi;
        logic [SAMPLE_W-1:0] lo;
        logic [SAMPLE_W-1:0] res;
        logic                res_vld;
    } st_t;

    st_t st_d, st_q;

    grp_cfg_t            cfg;
    logic                start;
    logic [SAMPLE_W-1:0] hi_n, lo_n;
    logic [SUM_W-1:0]    total, trimmed;
    logic [CNT_W-1:0]    nxt_cnt;

    // Equal mode codes whenever a group continues, so the live code selects the group shape.
    olr_mode_decode #(.MODE_W(MODE_W)) u_dec (
        .mode_i (mode_i),
        .cfg_o  (cfg)
    );

    olr_extreme_track #(.W(SAMPLE_W)) u_ext (
        .start_i (start),
        .samp_i  (samp_i),
        .hi_q_i  (st_q.hi),
        .lo_q_i  (st_q.lo),
        .hi_d_o  (hi_n),
        .lo_d_o  (lo_n)
    );

    always_comb begin
        st_d         = st_q;
        st_d.res_vld = 1'b0;
        start        = (st_q.cnt == '0) || (mode_i != st_q.mode);
        total        = (start ? '0 : st_q.sum) + SUM_W'(samp_i);
        nxt_cnt      = (start ? '0 : st_q.cnt) + CNT_W'(1);
        trimmed      = cfg.reject ? (total - SUM_W'(hi_n) - SUM_W'(lo_n)) : total;

        if (start) begin
            st_d.cnt  = '0;
            st_d.mode = mode_i;
        end

        if (samp_vld_i) begin
            if (nxt_cnt == cfg.len) begin
                st_d.res     = SAMPLE_W'(trimmed >> cfg.shift);
                st_d.res_vld = 1'b1;
                st_d.cnt     = '0;
            end else begin
                st_d.cnt = nxt_cnt;
                st_d.sum = total;
                st_d.hi  = hi_n;
                st_d.lo  = lo_n;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_o     = st_q.res;
    assign res_vld_o = st_q.res_vld;

    assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_vld_i && mode_i == MODE_W'(0)) |=> (res_vld_o && res_o == $past(samp_i)));

    assert_alias_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_vld_i && (mode_i == MODE_W'(6) || mode_i == MODE_W'(7)))
            |=> (res_vld_o && res_o == $past(samp_i)));

    assert_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld_o |-> $past(samp_vld_i));

    assert_discard_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!samp_vld_i && st_q.cnt != '0 && mode_i != st_q.mode) |=> (st_q.cnt == '0 && !res_vld_o));

    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!samp_vld_i && mode_i == st_q.mode) |=> (!res_vld_o && $stable(st_q.cnt)));

    assert_lo_le_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) |-> (st_q.lo <= st_q.hi));
endmodule

// File: tb/olr_avg_filter_tb.sv
module olr_avg_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] samp_i = '0;
    logic        samp_vld_i = 1'b0;
    logic [2:0]  mode_i = '0;
    logic [11:0] res_o;
    logic        res_vld_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    olr_avg_filter dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .samp_i     (samp_i),
        .samp_vld_i (samp_vld_i),
        .mode_i     (mode_i),
        .res_o      (res_o),
        .res_vld_o  (res_vld_o)
    );

    // mode, base, stride, flip
    localparam int TV [8][4] = '{
        '{0, 'h123, 0,     0},
        '{1, 'h100, 'h103, 0},
        '{2, 10,    700,   'h0F0},
        '{3, 1,     1,     0},
        '{4, 'h800, 'h155, 'h3C3},
        '{5, 'hFFF, 0,     0},
        '{5, 'h7A0, 'h0E9, 'h505},
        '{4, 0,     'hFFF, 'h001}
    };

    function automatic int grp_len(int m);
        case (m)
            1: return 2;  2: return 4;  3: return 6;
            4: return 10; 5: return 18; default: return 1;
        endcase
    endfunction

    function automatic string tag_of(int m);
        case (m)
            1: return "R3"; 2: return "R4"; 3: return "R5";
            4: return "R6"; 5: return "R7"; default: return "R2";
        endcase
    endfunction

    function automatic int gen_samp(int base, int stride, int flip, int k);
        return ((base + k * stride) & 'hFFF) ^ (((k % 2) == 1) ? flip : 0);
    endfunction

    function automatic int ref_avg(int m, int base, int stride, int flip);
        int v [18];
        int n = grp_len(m);
        int s = 0;
        int lo = 0;
        int hi = n - 1;
        int kept;
        for (int k = 0; k < n; k++) v[k] = gen_samp(base, stride, flip, k);
        for (int a = 0; a < n; a++)
            for (int b = 0; b < n - 1 - a; b++)
                if (v[b] > v[b+1]) begin int t = v[b]; v[b] = v[b+1]; v[b+1] = t; end
        if (n > 2) begin lo = 1; hi = n - 2; end
        for (int k = lo; k <= hi; k++) s += v[k];
        kept = hi - lo + 1;
        return s / kept;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input int s, input int m);
        @(negedge clk);
        mode_i = 3'(m); samp_i = 12'(s); samp_vld_i = 1'b1;
    endtask

    task automatic idle(input int m);
        @(negedge clk);
        mode_i = 3'(m); samp_vld_i = 1'b0;
    endtask

    task automatic expect_res(input int exp, input string tag);
        chk(res_vld_o == 1'b1, tag, int'(res_vld_o), 1);
        chk(res_o == 12'(exp), tag, int'(res_o), exp);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        bit early;
        repeat (3) @(negedge clk);
        chk(res_vld_o == 1'b0, "R1", int'(res_vld_o), 0);
        chk(res_o == 12'd0, "R1", int'(res_o), 0);
        rst_n = 1'b1;

        // table walk over every mode
        for (int i = 0; i < 8; i++) begin
            int m = TV[i][0];
            early = 1'b0;
            for (int k = 0; k < grp_len(m); k++) begin
                push(gen_samp(TV[i][1], TV[i][2], TV[i][3], k), m);
                if (k > 0 && res_vld_o) early = 1'b1;
            end
            chk(!early, "R12", int'(early), 0);
            idle(m);
            expect_res(ref_avg(m, TV[i][1], TV[i][2], TV[i][3]), tag_of(m));
            idle(m);
            chk(res_vld_o == 1'b0, "R12", int'(res_vld_o), 0);
        end

        // R3: truncation of odd pair sum
        push(1, 1); push(2, 1); idle(1);
        expect_res(1, "R3");

        // R8: duplicated extremes, one copy each removed -> (3+7)>>1
        push(7, 2); push(7, 2); push(3, 2); push(3, 2); idle(2);
        expect_res(5, "R8");
        push(100, 3); push(100, 3); push(100, 3);
        push(100, 3); push(100, 3); push(100, 3); idle(3);
        expect_res(100, "R8");

        // R9: aliases of mode 0
        push('hABC, 6); idle(6);
        expect_res('hABC, "R9");
        push('h5A5, 7); idle(7);
        expect_res('h5A5, "R9");

        // R10: mode change carrying a sample in the same cycle
        push(100, 3); push(200, 3); push(300, 3);
        push(10, 1);
        chk(res_vld_o == 1'b0, "R10", int'(res_vld_o), 0);
        push(20, 1);
        chk(res_vld_o == 1'b0, "R10", int'(res_vld_o), 0);
        idle(1);
        expect_res(15, "R10");

        // R10: drop on idle cycle, then a clean group
        push(1000, 2); push(2000, 2); idle(0); idle(2);
        early = 1'b0;
        push(8, 2); push(4, 2); push(6, 2);
        if (res_vld_o) early = 1'b1;
        push(2, 2);
        if (res_vld_o) early = 1'b1;
        chk(!early, "R10", int'(early), 0);
        idle(2);
        expect_res(5, "R10");

        // R11: gaps inside a pair
        push(40, 1);
        early = 1'b0;
        for (int g = 0; g < 3; g++) begin
            idle(1);
            if (res_vld_o) early = 1'b1;
        end
        chk(!early, "R11", int'(early), 0);
        push(51, 1); idle(1);
        expect_res(45, "R11");

        // R1: reset in the middle of a group
        push(500, 4); push(600, 4);
        @(negedge clk); samp_vld_i = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk(res_vld_o == 1'b0 && res_o == 12'd0, "R1", int'(res_o), 0);
        push(30, 1); push(31, 1); idle(1);
        expect_res(30, "R1");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule